// File: doc/BRIEF.md
# Serial Port Status Flags with Mode-Fault Detection

This block holds the two status flags of a synchronous serial port that can run as bus master or as slave. One flag reports that a received word is waiting in the receive data register. The other is a single error flag that covers two faults. In master mode the fault is a conflict: another device pulls chip-select low. In slave mode the fault is an incomplete transfer: the master releases chip-select while a transfer is still running.

Software clears a flag by reading the status register and then writing 0 to that flag's bit. The receive flag also clears when the receive data register is read, by the CPU or by a DMA transfer. When the error flag sets, the block asserts a halt signal that stops the serial sequencer. Clearing the error flag does not lift the halt. Only a sequencer reset lifts it.

The chip-select pin is asynchronous, so the block passes it through a synchronizer before it looks for levels or edges.

Top module: `sflag_top`

## Requirements
- R1: After reset, `rx_full_o`, `err_o`, `halt_o` and `busy_o` are all 0.
- R2: A pulse on `xfer_done_i` sets `rx_full_o` at the next clock edge. If a clear event for the receive flag happens in the same cycle, the set takes priority.
- R3: A pulse on `data_rd_i` or on `dma_rd_i` clears `rx_full_o` at the next clock edge, unless a set happens in the same cycle.
- R4: Status register write clearing. Bit 0 of the status word is the receive flag and bit 1 is the error flag. A status write with 0 in a flag's bit clears that flag at the next edge, but only if an earlier status read saw that flag as 1. Every status write uses up that read, whatever data it carries. A write of 1 never changes a flag. A write of 0 that was not preceded by such a read leaves the flag set.
- R5: `stat_rdata_o` always equals {`err_o`, `rx_full_o`} in the same cycle.
- R6: Master-mode conflict (`master_i`=1). When `cs_n_i` goes low, `err_o` rises on the third clock edge after the change: two synchronizer stages plus the flag register. `err_o` is still 0 after the second edge.
- R7: Slave-mode incomplete error (`master_i`=0). A rise of `cs_n_i` while `busy_o` is 1 sets `err_o` on the third edge. A rise while `busy_o` is 0 does not set `err_o`. A low level on `cs_n_i` does not set it either.
- R8: `halt_o` is 1 whenever `err_o` is 1. Once a fault has occurred, `halt_o` stays 1 after `err_o` is cleared, until a sequencer reset.
- R9: A pulse on `seq_rst_i` clears `halt_o` and `busy_o` at the next edge. It leaves `rx_full_o` and `err_o` unchanged.
- R10: `busy_o` follows `xfer_active_i` with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_done_i | input | 1 | Strobe: a received word moved from the shift register to the receive data register |
| data_rd_i | input | 1 | Strobe: CPU read of the receive data register |
| dma_rd_i | input | 1 | Strobe: DMA read of the receive data register |
| stat_rd_i | input | 1 | Strobe: status register read |
| stat_wr_i | input | 1 | Strobe: status register write |
| stat_wdata_i | input | 2 | Status write data (bit 1 error, bit 0 receive) |
| cs_n_i | input | 1 | Chip-select pin, asynchronous, idle high |
| master_i | input | 1 | 1 = master mode, 0 = slave mode |
| xfer_active_i | input | 1 | Transfer in progress, from the sequencer |
| seq_rst_i | input | 1 | Sequencer reset request |
| stat_rdata_o | output | 2 | Status read data {error, receive} |
| rx_full_o | output | 1 | Receive data register full flag |
| err_o | output | 1 | Conflict/incomplete error flag |
| halt_o | output | 1 | Stops the serial sequencer |
| busy_o | output | 1 | Registered transfer-active state |

## Verification
The assertions take the strobes to be single-cycle pulses sampled on the rising edge. They also take `stat_wdata_i` to be meaningful only while `stat_wr_i` is high. The bench drives every input at the falling edge and holds each strobe for exactly one cycle. It keeps `cs_n_i` steady long enough for the two-stage synchronizer to settle before it checks anything. It changes `master_i` and `xfer_active_i` only while chip-select is idle, so no mode switch can create a spurious edge.

// File: rtl/sflag_pkg.sv
// Package: shared constants and types for the serial status flag block.
// Assumes two flags; the bit positions are also the status word layout.
package sflag_pkg;
    localparam int NUM_FLAGS = 2;
    localparam int FLAG_RXF  = 0;
    localparam int FLAG_ERR  = 1;

    // Set and hardware-clear request for one flag in one cycle.
    typedef struct packed {
        logic set;
        logic hw_clr;
    } flag_evt_t;
endpackage

// File: rtl/sflag_sync.sv
// Module: sflag_sync
// Brings an asynchronous active-low pin into the clock domain through
// STAGES flops, then presents the synchronized level and a 0-to-1 edge.
// Assumes the pin idles high, so every stage resets to 1.
module sflag_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o
);
    localparam int LAST = STAGES;
    localparam int TAP  = STAGES - 1;

    logic [LAST:0] chain_q;

    // Shift the pin through the synchronizer and one extra history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[LAST-1:0], pin_i};
        end
    end

    // Synchronized level and rising edge taken from the last two stages.
    always_comb begin
        level_o = chain_q[TAP];
        rise_o  = chain_q[TAP] & ~chain_q[LAST];
    end
endmodule

// File: rtl/sflag_cell.sv
// Module: sflag_cell
// One status flag with a read-before-clear latch. A status read that sees
// the flag at 1 arms the latch. A status write of 0 clears the flag only
// when the latch is armed, and every write disarms the latch. A set event
// beats every clear event in the same cycle.
// Assumes all strobes are single-cycle and synchronous to clk.
module sflag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic hw_clr_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);
    logic flag_q;
    logic seen_q;
    logic flag_d;
    logic seen_d;
    logic sw_clr;

    // Next-state logic: set has priority over hardware and software clear.
    always_comb begin
        sw_clr = wr_i & ~wbit_i & seen_q;
        if (set_i) begin
            flag_d = 1'b1;
        end else if (hw_clr_i | sw_clr) begin
            flag_d = 1'b0;
        end else begin
            flag_d = flag_q;
        end
        if (wr_i) begin
            seen_d = 1'b0;
        end else begin
            seen_d = seen_q | (rd_i & flag_q);
        end
        seen_d = seen_d & flag_d;
    end

    // Flag and latch registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
            seen_q <= seen_d;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/sflag_fault.sv
// Module: sflag_fault
// Mode-fault detection and sequencer control. In master mode a low
// synchronized chip-select is a conflict. In slave mode a chip-select
// rise while busy is an incomplete transfer. A fault arms a sticky halt
// that only a sequencer reset removes. The module also keeps the
// registered transfer-active state, which the sequencer reset clears.
// Assumes the chip-select inputs are already synchronized.
module sflag_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic master_i,
    input  logic cs_level_i,
    input  logic cs_rise_i,
    input  logic xfer_active_i,
    input  logic seq_rst_i,
    input  logic err_i,
    output logic fault_o,
    output logic halt_o,
    output logic busy_o
);
    logic halt_q;
    logic act_q;
    logic conflict;
    logic incomplete;

    // Fault decode for the current mode.
    always_comb begin
        conflict   = master_i & ~cs_level_i;
        incomplete = ~master_i & cs_rise_i & act_q;
        fault_o    = conflict | incomplete;
    end

    // Sticky halt: a fault sets it (and wins), a sequencer reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
        end else if (fault_o) begin
            halt_q <= 1'b1;
        end else if (seq_rst_i) begin
            halt_q <= 1'b0;
        end
    end

    // Registered transfer-active state, forced idle by a sequencer reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
        end else if (seq_rst_i) begin
            act_q <= 1'b0;
        end else begin
            act_q <= xfer_active_i;
        end
    end

    assign halt_o = halt_q | err_i;
    assign busy_o = act_q;
endmodule

// File: rtl/sflag_top.sv
// Module: sflag_top
// Status flags of a master/slave synchronous serial port: receive-full
// and conflict/incomplete error, with a halt output to the sequencer.
// Assumes strobes are single-cycle; the chip-select pin is asynchronous.
module sflag_top #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xfer_done_i,
    input  logic       data_rd_i,
    input  logic       dma_rd_i,
    input  logic       stat_rd_i,
    input  logic       stat_wr_i,
    input  logic [1:0] stat_wdata_i,
    input  logic       cs_n_i,
    input  logic       master_i,
    input  logic       xfer_active_i,
    input  logic       seq_rst_i,
    output logic [1:0] stat_rdata_o,
    output logic       rx_full_o,
    output logic       err_o,
    output logic       halt_o,
    output logic       busy_o
);
    import sflag_pkg::*;

    logic                 cs_level;
    logic                 cs_rise;
    logic                 fault;
    logic [NUM_FLAGS-1:0] flags;
    flag_evt_t            evt [NUM_FLAGS];

    sflag_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (cs_n_i),
        .level_o (cs_level),
        .rise_o  (cs_rise)
    );

    sflag_fault u_fault (
        .clk           (clk),
        .rst_n         (rst_n),
        .master_i      (master_i),
        .cs_level_i    (cs_level),
        .cs_rise_i     (cs_rise),
        .xfer_active_i (xfer_active_i),
        .seq_rst_i     (seq_rst_i),
        .err_i         (flags[FLAG_ERR]),
        .fault_o       (fault),
        .halt_o        (halt_o),
        .busy_o        (busy_o)
    );

    // Route the hardware events to each flag.
    always_comb begin
        evt[FLAG_RXF].set    = xfer_done_i;
        evt[FLAG_RXF].hw_clr = data_rd_i | dma_rd_i;
        evt[FLAG_ERR].set    = fault;
        evt[FLAG_ERR].hw_clr = 1'b0;
    end

    // One flag cell per status bit.
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        sflag_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (evt[g].set),
            .hw_clr_i (evt[g].hw_clr),
            .rd_i     (stat_rd_i),
            .wr_i     (stat_wr_i),
            .wbit_i   (stat_wdata_i[g]),
            .flag_o   (flags[g])
        );
    end

    assign stat_rdata_o = flags;
    assign rx_full_o    = flags[FLAG_RXF];
    assign err_o        = flags[FLAG_ERR];
endmodule

// File: rtl/sflag_chk.sv
// Module: sflag_chk
// Checker with properties over the top-level ports, attached by bind.
module sflag_chk (
    input logic clk,
    input logic rst_n,
    input logic xfer_done_i,
    input logic data_rd_i,
    input logic stat_wr_i,
    input logic wbit_err_i,
    input logic seq_rst_i,
    input logic rx_full_o,
    input logic err_o,
    input logic halt_o,
    input logic busy_o
);
    // R2: a transfer strobe always leaves the receive flag set.
    assert_rx_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done_i |=> rx_full_o);

    // R3: a data read without a concurrent set clears the receive flag.
    assert_rx_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd_i && !xfer_done_i) |=> !rx_full_o);

    // R4: writing 1 to the error bit never clears it.
    assert_wr1_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_i && wbit_err_i && err_o) |=> err_o);

    // R8: the error flag rising always comes with halt.
    assert_err_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> halt_o);

    // R8: halt is held without a sequencer reset or status write.
    assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_o && !seq_rst_i && !stat_wr_i) |=> halt_o);

    // R9: a sequencer reset leaves the block idle.
    assert_seq_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_rst_i |=> !busy_o);
endmodule

bind sflag_top sflag_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_done_i (xfer_done_i),
    .data_rd_i   (data_rd_i),
    .stat_wr_i   (stat_wr_i),
    .wbit_err_i  (stat_wdata_i[1]),
    .seq_rst_i   (seq_rst_i),
    .rx_full_o   (rx_full_o),
    .err_o       (err_o),
    .halt_o      (halt_o),
    .busy_o      (busy_o)
);

// File: tb/sflag_top_bench.sv
module sflag_top_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       xfer_done_i, data_rd_i, dma_rd_i, stat_rd_i, stat_wr_i;
    logic [1:0] stat_wdata_i;
    logic       cs_n_i, master_i, xfer_active_i, seq_rst_i;
    logic [1:0] stat_rdata_o;
    logic       rx_full_o, err_o, halt_o, busy_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sflag_top u_sflag_top (
        .clk(clk), .rst_n(rst_n), .xfer_done_i(xfer_done_i), .data_rd_i(data_rd_i),
        .dma_rd_i(dma_rd_i), .stat_rd_i(stat_rd_i), .stat_wr_i(stat_wr_i),
        .stat_wdata_i(stat_wdata_i), .cs_n_i(cs_n_i), .master_i(master_i),
        .xfer_active_i(xfer_active_i), .seq_rst_i(seq_rst_i),
        .stat_rdata_o(stat_rdata_o), .rx_full_o(rx_full_o), .err_o(err_o),
        .halt_o(halt_o), .busy_o(busy_o)
    );

    // Row: [8]done [7]data_rd [6]dma_rd [5]stat_rd [4]stat_wr [3:2]wdata [1]exp_rxf [0]exp_err
    localparam int NV = 16;
    localparam logic [8:0] VEC [NV] = '{
        9'b1_0_0_0_0_00_1_0,  // R2 set
        9'b0_0_0_0_0_00_1_0,  // idle hold
        9'b0_0_0_0_1_00_1_0,  // R4 write 0 without read
        9'b0_0_0_1_0_00_1_0,  // status read arms latch
        9'b0_0_0_0_1_01_1_0,  // R4 write 1, latch consumed
        9'b0_0_0_0_1_00_1_0,  // R4 latch already consumed
        9'b0_0_0_1_0_00_1_0,  // read
        9'b0_0_0_0_1_00_0_0,  // R4 clear
        9'b1_0_0_0_0_00_1_0,  // set
        9'b0_1_0_0_0_00_0_0,  // R3 CPU read clears
        9'b1_0_0_0_0_00_1_0,  // set
        9'b0_0_1_0_0_00_0_0,  // R3 DMA read clears
        9'b1_1_0_0_0_00_1_0,  // R2 set beats data read
        9'b0_0_0_1_0_00_1_0,  // read
        9'b1_0_0_0_1_00_1_0,  // R2 set beats write clear
        9'b0_0_0_0_1_00_1_0   // R4 latch consumed by previous write
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        xfer_done_i = 0; data_rd_i = 0; dma_rd_i = 0; stat_rd_i = 0;
        stat_wr_i = 0; stat_wdata_i = 2'b00; seq_rst_i = 0;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic stat_clear(input logic [1:0] wd);
        stat_rd_i = 1; cyc(1); idle();
        stat_wr_i = 1; stat_wdata_i = wd; cyc(1); idle();
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        cs_n_i = 1; master_i = 1; xfer_active_i = 0; rst_n = 0;
        cyc(3);
        rst_n = 1;
        cyc(1);
        chk("R1", {4'd0, rx_full_o, err_o, halt_o, busy_o}, 8'd0);

        for (int v = 0; v < NV; v++) begin
            {xfer_done_i, data_rd_i, dma_rd_i, stat_rd_i, stat_wr_i, stat_wdata_i} = VEC[v][8:2];
            cyc(1);
            idle();
            chk("R2/R3/R4 rxf", {7'd0, rx_full_o}, {7'd0, VEC[v][1]});
            chk("R2/R3/R4 err", {7'd0, err_o}, {7'd0, VEC[v][0]});
        end
        chk("R5", {6'd0, stat_rdata_o}, {6'd0, err_o, rx_full_o});

        // R6 master conflict timing
        cs_n_i = 0; cyc(2);
        chk("R6 early", {7'd0, err_o}, 8'd0);
        cyc(1);
        chk("R6 set", {7'd0, err_o}, 8'd1);
        chk("R8 halt with err", {7'd0, halt_o}, 8'd1);
        chk("R5 both", {6'd0, stat_rdata_o}, 8'd3);
        cs_n_i = 1; cyc(3);
        stat_clear(2'b01);
        chk("R4 err cleared", {7'd0, err_o}, 8'd0);
        chk("R4 rxf kept", {7'd0, rx_full_o}, 8'd1);
        chk("R8 halt sticky", {7'd0, halt_o}, 8'd1);
        cyc(3);
        chk("R8 halt still", {7'd0, halt_o}, 8'd1);
        seq_rst_i = 1; cyc(1); idle();
        chk("R9 halt cleared", {7'd0, halt_o}, 8'd0);
        chk("R9 rxf kept", {7'd0, rx_full_o}, 8'd1);

        // R10 busy tracking and R9 busy clear
        xfer_active_i = 1; cyc(1);
        chk("R10 busy", {7'd0, busy_o}, 8'd1);
        seq_rst_i = 1; cyc(1); idle();
        chk("R9 busy cleared", {7'd0, busy_o}, 8'd0);
        cyc(1);
        chk("R10 busy again", {7'd0, busy_o}, 8'd1);

        // R7 slave mode
        master_i = 0; cyc(2);
        cs_n_i = 0; cyc(4);
        chk("R7 low no fault", {7'd0, err_o}, 8'd0);
        cs_n_i = 1; cyc(2);
        chk("R7 early", {7'd0, err_o}, 8'd0);
        cyc(1);
        chk("R7 incomplete", {7'd0, err_o}, 8'd1);
        chk("R8 slave halt", {7'd0, halt_o}, 8'd1);
        stat_clear(2'b01);
        seq_rst_i = 1; cyc(1); idle();
        chk("R9 err/halt idle", {6'd0, err_o, halt_o}, 8'd0);
        xfer_active_i = 0; cyc(2);
        cs_n_i = 0; cyc(4);
        cs_n_i = 1; cyc(4);
        chk("R7 rise idle no fault", {6'd0, err_o, halt_o}, 8'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule